// File: doc/BRIEF.md
# Strobe-Based Bus Cycle Classifier

This block watches a processor bus with multiplexed active-low strobes. It samples them on a fast monitor clock. The strobes are an opcode-fetch marker, a read strobe, a write strobe, a memory-select strobe and an I/O-select strobe. The block also samples an 8-bit data bus and a 16-bit address bus. Each sample is sorted into one of seven cycle kinds. From the way the kind changes between samples, the block produces three single-cycle events:

- a cycle start, which carries the address seen on the first active sample;
- a cycle finish, which carries the last data byte seen and the kind of the cycle that ended;
- a warning, raised when the bus moves from one active kind straight to a different active kind.

Downstream logic, such as a disassembler, a trace buffer or a protocol checker, uses these events as its input. Every input passes through a two-stage synchroniser before it is classified. The select strobes may be left unconnected. Two static strap inputs tell the block whether each select strobe is fitted. When a strobe is not fitted, the block uses a fixed assumed level for it.

Top module: `strobe_cycle_sorter`

## Requirements
- R1: Cycle kinds are encoded as NONE=0, MEMRD=1, MEMWR=2, IORD=3, IOWR=4, FETCH=5 and INTACK=6. With the memory select low and the read strobe low, the kind is FETCH if the fetch marker is low and MEMRD otherwise. With the memory select low, the read strobe high and the write strobe low, the kind is MEMWR.
- R2: With the memory select high and the I/O select low, the kind is INTACK if the fetch marker is low. Otherwise it is IORD if the read strobe is low, and IOWR if the write strobe is low.
- R3: With the memory select low and both the read and write strobes high, the kind is NONE. The I/O select and the fetch marker are ignored in that case, so no event is produced.
- R4: When `mem_sel_fitted` is 0, the memory select is taken as asserted whatever its pin level. When `io_sel_fitted` is 0, the I/O select is taken as deasserted.
- R5: A change from NONE to an active kind pulses `begin_evt`. `begin_addr` holds the address sampled on that first active sample. Address changes later in the same cycle do not alter it.
- R6: A change from an active kind to NONE pulses `end_evt`. `end_data` holds the data byte from the last active sample. `end_kind` holds the kind of the cycle that ended.
- R7: A direct change between two different active kinds pulses `illegal_evt`. The cycle that then returns to NONE produces no `end_evt`. The next well-formed cycle reports normally.
- R8: An input change shows on the event outputs after exactly three rising clock edges. Each event lasts one clock cycle, and at most one of the three events is high in any cycle.
- R9: A synchronous active-high reset clears all events and returns the remembered kind to NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_n | input | 1 | Opcode-fetch marker, active low |
| read_n | input | 1 | Read strobe, active low |
| write_n | input | 1 | Write strobe, active low |
| mem_sel_n | input | 1 | Memory select strobe, active low |
| io_sel_n | input | 1 | I/O select strobe, active low |
| mem_sel_fitted | input | 1 | 1 when the memory select pin is connected |
| io_sel_fitted | input | 1 | 1 when the I/O select pin is connected |
| data_in | input | 8 | Data bus |
| addr_in | input | 16 | Address bus |
| begin_evt | output | 1 | Cycle-start pulse |
| begin_addr | output | 16 | Address captured at cycle start |
| end_evt | output | 1 | Cycle-finish pulse |
| end_data | output | 8 | Last data byte of the finished cycle |
| end_kind | output | 3 | Kind of the finished cycle |
| illegal_evt | output | 1 | Direct change between active kinds |

## Verification
The state the ports cannot show directly is held in three places: the remembered previous kind, the data hold register and the flag that marks a cycle as broken. A wrong previous kind shows up three edges after the next strobe change, as a missing start, a spurious warning or a wrong `end_kind`. A stale data hold appears as a wrong `end_data` on the very next finish. A broken-cycle flag that is stuck or never cleared shows in the same way: either a finish is reported after a warning, or the next clean cycle reports none. The directed scenarios drive each classification branch, the strap defaults and the warning sequence. The pulse timing is counted edge by edge.

// File: rtl/strobe_cycle_sorter.sv
`timescale 1ns/1ps
module strobe_cycle_sorter #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_n,
  input  logic          read_n,
  input  logic          write_n,
  input  logic          mem_sel_n,
  input  logic          io_sel_n,
  input  logic          mem_sel_fitted,
  input  logic          io_sel_fitted,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] addr_in,
  output logic          begin_evt,
  output logic [AW-1:0] begin_addr,
  output logic          end_evt,
  output logic [DW-1:0] end_data,
  output logic [KW-1:0] end_kind,
  output logic          illegal_evt
);
  localparam int SW = 5;
  localparam logic [KW-1:0] K_NONE  = KW'(0);
  localparam logic [KW-1:0] K_MRD   = KW'(1);
  localparam logic [KW-1:0] K_MWR   = KW'(2);
  localparam logic [KW-1:0] K_IRD   = KW'(3);
  localparam logic [KW-1:0] K_IWR   = KW'(4);
  localparam logic [KW-1:0] K_FETCH = KW'(5);
  localparam logic [KW-1:0] K_IACK  = KW'(6);

  logic [SW-1:0] st1, st2;
  logic [DW-1:0] d1, d2, data_hold;
  logic [AW-1:0] a1, a2;
  logic [KW-1:0] kind_now, kind_prev;
  logic          broken;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= '1;
      st2 <= '1;
      d1  <= '0;
      d2  <= '0;
      a1  <= '0;
      a2  <= '0;
    end else begin
      st1 <= {fetch_n, read_n, write_n, mem_sel_n, io_sel_n};
      st2 <= st1;
      d1  <= data_in;
      d2  <= d1;
      a1  <= addr_in;
      a2  <= a1;
    end
  end

  wire fm_act = ~st2[4];
  wire rd_act = ~st2[3];
  wire wr_act = ~st2[2];
  wire mq_act = mem_sel_fitted ? ~st2[1] : 1'b1;
  wire iq_act = io_sel_fitted  ? ~st2[0] : 1'b0;

  always_comb begin
    kind_now = K_NONE;
    if (mq_act) begin
      if (rd_act)      kind_now = fm_act ? K_FETCH : K_MRD;
      else if (wr_act) kind_now = K_MWR;
    end else if (iq_act) begin
      if (fm_act)      kind_now = K_IACK;
      else if (rd_act) kind_now = K_IRD;
      else if (wr_act) kind_now = K_IWR;
    end
  end

  wire now_act  = kind_now  != K_NONE;
  wire prev_act = kind_prev != K_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_prev   <= K_NONE;
      data_hold   <= '0;
      broken      <= 1'b0;
      begin_evt   <= 1'b0;
      begin_addr  <= '0;
      end_evt     <= 1'b0;
      end_data    <= '0;
      end_kind    <= K_NONE;
      illegal_evt <= 1'b0;
    end else begin
      begin_evt   <= 1'b0;
      end_evt     <= 1'b0;
      illegal_evt <= 1'b0;
      kind_prev   <= kind_now;
      if (now_act) data_hold <= d2;
      if (now_act && !prev_act) begin
        begin_evt  <= 1'b1;
        begin_addr <= a2;
        broken     <= 1'b0;
      end else if (!now_act && prev_act) begin
        end_evt  <= ~broken;
        end_data <= data_hold;
        end_kind <= kind_prev;
        broken   <= 1'b0;
      end else if (now_act && prev_act && kind_now != kind_prev) begin
        illegal_evt <= 1'b1;
        broken      <= 1'b1;
      end
    end
  end
endmodule

module strobe_cycle_sorter_chk #(
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          begin_evt,
  input logic          end_evt,
  input logic [KW-1:0] end_kind,
  input logic          illegal_evt
);
  p_one_event_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({begin_evt, end_evt, illegal_evt}) <= 1);
  p_begin_single_r5: assert property (@(posedge clk) disable iff (rst)
    begin_evt |=> !begin_evt);
  p_end_single_r6: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> !end_evt);
  p_end_kind_valid_r6: assert property (@(posedge clk) disable iff (rst)
    end_evt |-> (end_kind != '0 && end_kind <= KW'(6)));
  p_warn_no_finish_r7: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |=> (!end_evt && !begin_evt));
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!begin_evt && !end_evt && !illegal_evt));
endmodule

bind strobe_cycle_sorter strobe_cycle_sorter_chk #(.KW(KW)) u_chk (
  .clk(clk), .rst(rst), .begin_evt(begin_evt), .end_evt(end_evt),
  .end_kind(end_kind), .illegal_evt(illegal_evt)
);

// File: tb/strobe_cycle_sorter_bench.sv
`timescale 1ns/1ps
module strobe_cycle_sorter_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic fetch_n = 1'b1, read_n = 1'b1, write_n = 1'b1, mem_sel_n = 1'b1, io_sel_n = 1'b1;
  logic mem_sel_fitted = 1'b1, io_sel_fitted = 1'b1;
  logic [7:0] data_in = '0;
  logic [15:0] addr_in = '0;
  logic begin_evt, end_evt, illegal_evt;
  logic [15:0] begin_addr;
  logic [7:0] end_data;
  logic [2:0] end_kind;

  int checks = 0, failures = 0;
  int nb = 0, ne = 0, ni = 0;
  int last_addr = 0, last_data = 0, last_kind = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_cycle_sorter u_strobe_cycle_sorter (
    .clk(clk), .rst(rst), .fetch_n(fetch_n), .read_n(read_n), .write_n(write_n),
    .mem_sel_n(mem_sel_n), .io_sel_n(io_sel_n), .mem_sel_fitted(mem_sel_fitted),
    .io_sel_fitted(io_sel_fitted), .data_in(data_in), .addr_in(addr_in),
    .begin_evt(begin_evt), .begin_addr(begin_addr), .end_evt(end_evt),
    .end_data(end_data), .end_kind(end_kind), .illegal_evt(illegal_evt)
  );

  always @(negedge clk) if (!rst) begin
    if (begin_evt)   begin nb++; last_addr = int'(begin_addr); end
    if (end_evt)     begin ne++; last_data = int'(end_data); last_kind = int'(end_kind); end
    if (illegal_evt) ni++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic f, logic r, logic w, logic mq, logic iq, logic [7:0] d, logic [15:0] a);
    @(negedge clk);
    fetch_n = f; read_n = r; write_n = w; mem_sel_n = mq; io_sel_n = iq;
    data_in = d; addr_in = a;
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_and_clear();
    drive(1, 1, 1, 1, 1, 8'h00, 16'h0000);
    hold(6);
    nb = 0; ne = 0; ni = 0; last_addr = 0; last_data = 0; last_kind = 0;
  endtask

  task automatic one_cycle(string req, logic f, logic r, logic w, logic mq, logic iq,
                           logic [15:0] a, logic [7:0] d, int kind);
    settle_and_clear();
    drive(f, r, w, mq, iq, d, a);
    hold(3);
    drive(1, 1, 1, 1, 1, 8'hEE, 16'hBEEF);
    hold(6);
    check({req, " begins"}, nb, 1);
    check({req, " addr"}, last_addr, int'(a));
    check({req, " ends"}, ne, 1);
    check({req, " data"}, last_data, int'(d));
    check({req, " kind"}, last_kind, kind);
  endtask

  task automatic t_reset();
    hold(1);
    check("R9 begin after reset", int'(begin_evt), 0);
    check("R9 end after reset", int'(end_evt), 0);
    check("R9 illegal after reset", int'(illegal_evt), 0);
  endtask

  task automatic t_latency();
    settle_and_clear();
    drive(1, 0, 1, 0, 1, 8'h11, 16'h1234);
    @(negedge clk);
    check("R8 no pulse after one edge", int'(begin_evt), 0);
    @(negedge clk);
    check("R8 no pulse after two edges", int'(begin_evt), 0);
    @(negedge clk);
    check("R8 pulse after three edges", int'(begin_evt), 1);
    addr_in = 16'hFFFF; data_in = 8'h22;
    @(negedge clk);
    check("R8 pulse one cycle wide", int'(begin_evt), 0);
    data_in = 8'h5A;
    hold(3);
    drive(1, 1, 1, 1, 1, 8'h99, 16'h0001);
    hold(6);
    check("R5 address from first sample", last_addr, 16'h1234);
    check("R6 last data byte kept", last_data, 8'h5A);
    check("R1 memory read kind", last_kind, 1);
    check("R6 single finish", ne, 1);
  endtask

  task automatic t_classes();
    one_cycle("R1 fetch", 0, 0, 1, 0, 1, 16'h0000, 8'hC3, 5);
    one_cycle("R1 memory write", 1, 1, 0, 0, 1, 16'h8001, 8'hA5, 2);
    one_cycle("R2 io read", 1, 0, 1, 1, 0, 16'h00FE, 8'h3C, 3);
    one_cycle("R2 io write", 1, 1, 0, 1, 0, 16'h12FE, 8'h81, 4);
    one_cycle("R2 interrupt ack", 0, 1, 1, 1, 0, 16'h4000, 8'hFF, 6);
  endtask

  task automatic t_mem_no_strobe();
    settle_and_clear();
    drive(0, 1, 1, 0, 0, 8'h55, 16'h7777);
    hold(5);
    drive(1, 1, 1, 1, 1, 8'h00, 16'h0000);
    hold(6);
    check("R3 no begin", nb, 0);
    check("R3 no end", ne, 0);
  endtask

  task automatic t_straps();
    mem_sel_fitted = 1'b0;
    one_cycle("R4 memory select assumed", 1, 0, 1, 1, 1, 16'h2468, 8'h42, 1);
    mem_sel_fitted = 1'b1;
    io_sel_fitted = 1'b0;
    settle_and_clear();
    drive(1, 0, 1, 1, 0, 8'h10, 16'h0010);
    hold(5);
    drive(1, 1, 1, 1, 1, 8'h00, 16'h0000);
    hold(6);
    check("R4 io select assumed idle", nb + ne + ni, 0);
    io_sel_fitted = 1'b1;
  endtask

  task automatic t_illegal();
    settle_and_clear();
    drive(1, 0, 1, 0, 1, 8'h01, 16'h0100);
    hold(3);
    drive(1, 1, 0, 0, 1, 8'h02, 16'h0100);
    hold(3);
    drive(1, 1, 1, 1, 1, 8'h00, 16'h0000);
    hold(6);
    check("R7 warning raised", ni, 1);
    check("R7 broken cycle not finished", ne, 0);
    check("R7 single begin", nb, 1);
    one_cycle("R7 recovery", 1, 1, 0, 0, 1, 16'h0200, 8'h77, 2);
  endtask

  initial begin
    hold(4);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_classes();
    t_mem_no_strobe();
    t_straps();
    t_illegal();
    rst = 1'b1;
    hold(2);
    check("R9 quiet during reset", int'(begin_evt | end_evt | illegal_evt), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule